// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a register-mapped watchdog built on a 64-bit up-counter and a 64-bit period. Each of them is split into two 32-bit words. Software sets the period first. It also sets the run mode, releases both counter halves and selects watchdog mode. It then arms the block with two keyed writes to the watchdog control word. After arming, every control and count register is frozen, so only the key field of the watchdog control word still acts.

While the block is armed, the counter advances once per cycle in which the count-tick input is high. If software does not repeat the two-key service handshake before the counter reaches the period, the timeout flag sets and a one-cycle reset pulse is issued. A key arriving out of order counts as a fault and causes the same timeout at once. After a timeout, only the hardware reset returns the block to its inactive state.

Register reads return data one cycle after the address is presented. Byte offsets: 0x00 ident, 0x10/0x14 counter low/high, 0x18/0x1C period low/high, 0x20 timer control, 0x24 global control, 0x28 watchdog control. Every other offset reads as zero, including 0x04.

Top module: `key_wdog`

## Requirements
- R1: After reset the block is inactive, timeout_o and wdog_rst_o are low, the counter and period read zero, and every control field reads zero.
- R2: Read data for the address presented at one clock edge appears on rdata_o after that edge. Offset 0x00 returns the constant ID_VAL, and any unmapped offset (0x04 among them) returns zero.
- R3: Timer control keeps the run field in bits 7:6 (0 = stopped, 1 = single, 2 = continuous). Global control keeps the low-half release in bit 0, the high-half release in bit 1 and the mode in bits 3:2. All other bits of these registers read zero.
- R4: In the inactive state, a watchdog-control write with bits 31:16 = 0xA5C6 and bit 14 set moves the block to pre-active, but only while global control bits 3:2 equal 2; otherwise the write is ignored. Watchdog-control bit 14 reads 1 in every state except inactive.
- R5: In pre-active, a write of key 0xDA7E with bit 14 set makes the block active. While it is active, the counter adds one on each cycle with tick_i high, provided the run field is nonzero.
- R6: Once the block has left the inactive state, writes to the counter, period, timer control and global control registers leave their contents unchanged.
- R7: The counter is 64 bits wide, carries from the low word into the high word, and can be read and written by halves while inactive. A half whose release bit is 0 is held at zero.
- R8: When an active counter equals the 64-bit period, the block times out on the next edge. The counter then stops at the period value, and watchdog-control bit 15 reads 1.
- R9: While the block is active, key 0xA5C6 enters the service state. A following key 0xDA7E then clears the counter to zero and returns the block to active.
- R10: In pre-active, active or service, a watchdog-control write that does not carry the expected next key causes an immediate timeout.
- R11: A timeout raises wdog_rst_o for exactly one cycle and keeps timeout_o high until the hardware reset.
- R12: With the run field at 0, an armed block does not count, whatever tick_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Byte address of register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| tick_i | input | 1 | Count tick, one increment per high cycle |
| timeout_o | output | 1 | Sticky timeout flag |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit byte address, a 32-bit word and two counter halves. Because the period is a register, the bench can program small periods, and expiry, service and fault paths all complete within tens of cycles. Preloading the low counter word close to all ones while inactive brings the carry into the high half, and a period above 2^32, within a few ticks. Random periods, preloads and service points are mixed with directed checks of key faults, locking and half release.

// File: rtl/key_wdog_pkg.sv
package key_wdog_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned KW = 16;

  localparam logic [7:0] OFF_ID     = 8'h00;
  localparam logic [7:0] OFF_CNT_LO = 8'h10;
  localparam logic [7:0] OFF_CNT_HI = 8'h14;
  localparam logic [7:0] OFF_PRD_LO = 8'h18;
  localparam logic [7:0] OFF_PRD_HI = 8'h1C;
  localparam logic [7:0] OFF_TCTL   = 8'h20;
  localparam logic [7:0] OFF_GCTL   = 8'h24;
  localparam logic [7:0] OFF_WDCTL  = 8'h28;

  localparam int unsigned RUN_LSB  = 6;
  localparam int unsigned MODE_LSB = 2;
  localparam int unsigned EN_BIT   = 14;
  localparam int unsigned FLAG_BIT = 15;
  localparam int unsigned KEY_LSB  = 16;

  localparam logic [1:0]    MODE_WDOG = 2'd2;
  localparam logic [KW-1:0] KEY_ARM   = 16'hA5C6;
  localparam logic [KW-1:0] KEY_GO    = 16'hDA7E;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_SVC, ST_EXP
  } wd_state_e;
endpackage

// File: rtl/kw_counter.sv
module kw_counter #(
  parameter int unsigned HW = 32,
  parameter int unsigned NH = 2,
  localparam int unsigned CW = HW * NH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [NH-1:0] wr_i,
  input  logic [HW-1:0] wdata_i,
  input  logic [NH-1:0] rel_i,
  input  logic [CW-1:0] prd_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  logic [NH:0] carry;

  assign hit_o    = (cnt_o == prd_i);
  assign carry[0] = run_i & tick_i & ~hit_o;

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [HW-1:0] q;
    assign cnt_o[h*HW +: HW] = q;
    assign carry[h+1] = carry[h] & (&q);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= '0;
      else if (!rel_i[h]) q <= '0;
      else if (clr_i)     q <= '0;
      else if (wr_i[h])   q <= wdata_i;
      else if (carry[h])  q <= q + 1'b1;
    end
  end
endmodule

// File: rtl/kw_key_fsm.sv
module kw_key_fsm
  import key_wdog_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_wr_i,
  input  logic [KW-1:0] key_i,
  input  logic          en_i,
  input  logic          mode_ok_i,
  input  logic          hit_i,
  output wd_state_e     state_o,
  output logic          clr_o,
  output logic          rst_pulse_o
);
  wd_state_e state_q, state_d;
  logic      rst_q;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (key_wr_i && key_i == KEY_ARM && en_i && mode_ok_i) state_d = ST_PRE;
      ST_PRE:
        if (key_wr_i) state_d = (key_i == KEY_GO && en_i) ? ST_ACT : ST_EXP;
      ST_ACT:
        if (hit_i)         state_d = ST_EXP;
        else if (key_wr_i) state_d = (key_i == KEY_ARM) ? ST_SVC : ST_EXP;
      ST_SVC:
        if (hit_i) state_d = ST_EXP;
        else if (key_wr_i) begin
          if (key_i == KEY_GO) begin
            state_d = ST_ACT;
            clr_o   = 1'b1;
          end else begin
            state_d = ST_EXP;
          end
        end
      default: state_d = ST_EXP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_q   <= (state_d == ST_EXP) && (state_q != ST_EXP);
    end
  end

  assign state_o     = state_q;
  assign rst_pulse_o = rst_q;
endmodule

// File: rtl/kw_regs.sv
module kw_regs
  import key_wdog_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter logic [31:0] ID_VAL = 32'h5744_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          locked_i,
  input  logic          flag_i,
  input  logic [2*DW-1:0] cnt_i,
  output logic [2*DW-1:0] prd_o,
  output logic [1:0]    run_o,
  output logic [1:0]    rel_o,
  output logic [1:0]    mode_o,
  output logic [1:0]    cnt_wr_o,
  output logic          key_wr_o,
  output logic [DW-1:0] rdata_o
);
  logic wr_ok;
  logic [DW-1:0] rd_d, rd_q;

  function automatic logic hit_off(input logic [AW-1:0] a, input logic [7:0] off);
    return a == off[AW-1:0];
  endfunction

  assign wr_ok       = we_i & ~locked_i;
  assign cnt_wr_o[0] = wr_ok & hit_off(addr_i, OFF_CNT_LO);
  assign cnt_wr_o[1] = wr_ok & hit_off(addr_i, OFF_CNT_HI);
  assign key_wr_o    = we_i & hit_off(addr_i, OFF_WDCTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_o  <= '0;
      run_o  <= '0;
      rel_o  <= '0;
      mode_o <= '0;
    end else if (wr_ok) begin
      if (hit_off(addr_i, OFF_PRD_LO)) prd_o[DW-1:0]    <= wdata_i;
      if (hit_off(addr_i, OFF_PRD_HI)) prd_o[2*DW-1:DW] <= wdata_i;
      if (hit_off(addr_i, OFF_TCTL))   run_o <= wdata_i[RUN_LSB +: 2];
      if (hit_off(addr_i, OFF_GCTL)) begin
        rel_o  <= wdata_i[1:0];
        mode_o <= wdata_i[MODE_LSB +: 2];
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if      (hit_off(addr_i, OFF_ID))     rd_d = ID_VAL;
    else if (hit_off(addr_i, OFF_CNT_LO)) rd_d = cnt_i[DW-1:0];
    else if (hit_off(addr_i, OFF_CNT_HI)) rd_d = cnt_i[2*DW-1:DW];
    else if (hit_off(addr_i, OFF_PRD_LO)) rd_d = prd_o[DW-1:0];
    else if (hit_off(addr_i, OFF_PRD_HI)) rd_d = prd_o[2*DW-1:DW];
    else if (hit_off(addr_i, OFF_TCTL))   rd_d[RUN_LSB +: 2] = run_o;
    else if (hit_off(addr_i, OFF_GCTL))   rd_d[3:0] = {mode_o, rel_o};
    else if (hit_off(addr_i, OFF_WDCTL)) begin
      rd_d[FLAG_BIT] = flag_i;
      rd_d[EN_BIT]   = locked_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/key_wdog.sv
module key_wdog
  import key_wdog_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter logic [31:0] ID_VAL = 32'h5744_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          tick_i,
  output logic          timeout_o,
  output logic          wdog_rst_o
);
  localparam int unsigned NH = 2;
  localparam int unsigned CW = NH * DW;

  wd_state_e       state_w;
  logic [CW-1:0]   cnt_w, prd_w;
  logic [1:0]      run_w, rel_w, mode_w, cnt_wr_w;
  logic            key_wr_w, clr_w, hit_w, armed_w, locked_w;

  assign locked_w  = (state_w != ST_IDLE);
  assign armed_w   = (state_w == ST_ACT) || (state_w == ST_SVC);
  assign timeout_o = (state_w == ST_EXP);

  kw_regs #(.AW(AW), .ID_VAL(ID_VAL)) i_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .locked_i (locked_w),
    .flag_i   (timeout_o),
    .cnt_i    (cnt_w),
    .prd_o    (prd_w),
    .run_o    (run_w),
    .rel_o    (rel_w),
    .mode_o   (mode_w),
    .cnt_wr_o (cnt_wr_w),
    .key_wr_o (key_wr_w),
    .rdata_o
  );

  kw_key_fsm i_fsm (
    .clk_i, .rst_ni,
    .key_wr_i    (key_wr_w),
    .key_i       (wdata_i[KEY_LSB +: KW]),
    .en_i        (wdata_i[EN_BIT]),
    .mode_ok_i   (mode_w == MODE_WDOG),
    .hit_i       (hit_w & armed_w),
    .state_o     (state_w),
    .clr_o       (clr_w),
    .rst_pulse_o (wdog_rst_o)
  );

  kw_counter #(.HW(DW), .NH(NH)) i_cnt (
    .clk_i, .rst_ni,
    .run_i   (armed_w && run_w != 2'd0),
    .tick_i,
    .clr_i   (clr_w),
    .wr_i    (cnt_wr_w),
    .wdata_i,
    .rel_i   (rel_w),
    .prd_i   (prd_w),
    .cnt_o   (cnt_w),
    .hit_o   (hit_w)
  );
endmodule

// File: rtl/kw_chk.sv
module kw_chk
  import key_wdog_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          we_i,
  input logic          tick_i,
  input logic          timeout_o,
  input logic          wdog_rst_o,
  input logic          clr_w,
  input logic          locked_w,
  input logic [63:0]   cnt_w,
  input logic [63:0]   prd_w
);
  // R11
  rst_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |=> !wdog_rst_o);

  // R11
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);

  // R11
  pulse_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> wdog_rst_o);

  // R6
  prd_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_w && we_i && addr_i == OFF_PRD_LO[AW-1:0]) |=> $stable(prd_w));

  // R9
  svc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |=> (cnt_w == 64'd0));

  // R5
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_w && !tick_i && !clr_w) |=> $stable(cnt_w));
endmodule

bind key_wdog kw_chk #(.AW(AW)) i_kw_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .tick_i, .timeout_o, .wdog_rst_o,
  .clr_w, .locked_w, .cnt_w, .prd_w
);

// File: tb/test_key_wdog.sv
module test_key_wdog;
  localparam logic [31:0] ID_C = 32'h5744_0001;
  localparam logic [7:0] A_ID = 8'h00, A_EMU = 8'h04, A_CL = 8'h10, A_CH = 8'h14,
                         A_PL = 8'h18, A_PH = 8'h1C, A_TC = 8'h20, A_GC = 8'h24,
                         A_WD = 8'h28;
  localparam logic [31:0] GC_OK = 32'h0000_000B;
  localparam logic [31:0] TC_CONT = 32'h0000_0080;
  localparam logic [31:0] W_ARM = 32'hA5C6_4000, W_GO = 32'hDA7E_4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic we = 1'b0, tick = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic timeout, wrst;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  key_wdog #(.AW(8), .ID_VAL(ID_C)) i_key_wdog (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .timeout_o(timeout), .wdog_rst_o(wrst));

  function automatic logic [31:0] exp_wd(input logic armed, input logic flag);
    return {16'h0, flag, armed, 14'h0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; we = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic do_reset();
    tick = 1'b0; we = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input logic [63:0] prd, input logic [63:0] pre, input logic [31:0] tc);
    wr(A_GC, GC_OK);
    wr(A_TC, tc);
    wr(A_PL, prd[31:0]);
    wr(A_PH, prd[63:32]);
    wr(A_CL, pre[31:0]);
    wr(A_CH, pre[63:32]);
  endtask

  task automatic arm();
    wr(A_WD, W_ARM);
    wr(A_WD, W_GO);
  endtask

  // tick held high from the current negedge; counter at cur; expiry expected
  task automatic run_to_expiry(input string req, input logic [63:0] cur, input logic [63:0] prd);
    int unsigned n = int'(prd - cur);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    check({req, " flag low before expiry"}, timeout, 0);
    @(negedge clk);
    check({req, " flag set"}, timeout, 1);
    check("R11 reset pulse high", wrst, 1);
    @(negedge clk);
    check("R11 reset pulse ends", wrst, 0);
    check("R11 flag held", timeout, 1);
    tick = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1234_5678));
    do_reset();

    // R1 reset state
    check("R1 timeout_o", timeout, 0);
    check("R1 wdog_rst_o", wrst, 0);
    rd(A_CL, v); check("R1 counter low", v, 0);
    rd(A_PH, v); check("R1 period high", v, 0);
    rd(A_GC, v); check("R1 global ctl", v, 0);
    rd(A_WD, v); check("R1 watchdog ctl", v, exp_wd(0, 0));

    // R2 ident and unmapped
    rd(A_ID, v);  check("R2 ident", v, ID_C);
    rd(A_EMU, v); check("R2 offset 0x04", v, 0);
    rd(8'h2C, v); check("R2 offset 0x2C", v, 0);
    addr = A_ID; @(negedge clk); addr = A_PL;
    check("R2 one-cycle latency", rdata, ID_C);
    @(negedge clk);

    // R3 field readback, other bits dropped
    wr(A_TC, 32'hFFFF_FF7F); rd(A_TC, v); check("R3 timer ctl fields", v, 32'h40);
    wr(A_GC, 32'hFFFF_FFF6); rd(A_GC, v); check("R3 global ctl fields", v, 32'h6);

    // R7 half release: low held at zero while bit0 clear
    wr(A_CL, 32'h0000_0055); rd(A_CL, v); check("R7 low half held", v, 0);
    wr(A_CH, 32'h0000_0077); rd(A_CH, v); check("R7 high half writable", v, 32'h77);

    // R4 arm refused without watchdog mode (bits 3:2 = 1 here)
    wr(A_GC, 32'h0000_0007);
    wr(A_WD, W_ARM);
    rd(A_WD, v); check("R4 arm refused", v, exp_wd(0, 0));
    wr(A_WD, W_GO);
    check("R4 stray key ignored while inactive", timeout, 0);

    // R8 basic expiry, R5 counting
    do_reset();
    setup(64'd10, 64'd3, TC_CONT);
    wr(A_WD, W_ARM);
    rd(A_WD, v); check("R4 pre-active enable bit", v, exp_wd(1, 0));
    wr(A_WD, W_GO);
    tick = 1'b1; repeat (4) @(negedge clk); tick = 1'b0;
    rd(A_CL, v); check("R5 counted ticks", v, 7);
    run_to_expiry("R8", 64'd7, 64'd10);
    rd(A_CL, v); check("R8 counter stops at period", v, 10);
    rd(A_WD, v); check("R8 flag bit 15", v, exp_wd(1, 1));

    // R6 write protection
    do_reset();
    setup(64'd20, 64'd0, TC_CONT);
    arm();
    wr(A_PL, 32'd3); wr(A_TC, 32'h0); wr(A_GC, 32'h0); wr(A_CL, 32'd9);
    rd(A_PL, v); check("R6 period locked", v, 20);
    rd(A_TC, v); check("R6 timer ctl locked", v, TC_CONT);
    rd(A_GC, v); check("R6 global ctl locked", v, GC_OK);
    rd(A_CL, v); check("R6 counter locked", v, 0);

    // R7 carry into high half, period above 2^32
    do_reset();
    setup(64'h1_0000_0002, 64'h0_FFFF_FFFE, TC_CONT);
    arm();
    tick = 1'b1; repeat (2) @(negedge clk); tick = 1'b0;
    rd(A_CH, v); check("R7 carry high", v, 1);
    rd(A_CL, v); check("R7 carry low", v, 0);
    run_to_expiry("R7", 64'h1_0000_0000, 64'h1_0000_0002);

    // R12 run field stopped
    do_reset();
    setup(64'd5, 64'd2, 32'h0);
    arm();
    tick = 1'b1; repeat (30) @(negedge clk); tick = 1'b0;
    rd(A_CL, v); check("R12 no counting", v, 2);
    check("R12 no timeout", timeout, 0);

    // R10 wrong key while active
    do_reset();
    setup(64'd50, 64'd0, TC_CONT);
    arm();
    wr(A_WD, 32'h1234_4000);
    check("R10 bad key active", timeout, 1);
    check("R11 pulse on fault", wrst, 1);
    @(negedge clk);
    check("R11 pulse one cycle", wrst, 0);
    do_reset();
    rd(A_WD, v); check("R11 hardware reset clears", v, exp_wd(0, 0));

    // R10 go key without enable in pre-active
    setup(64'd50, 64'd0, TC_CONT);
    wr(A_WD, W_ARM);
    wr(A_WD, 32'hDA7E_0000);
    check("R10 bad key pre-active", timeout, 1);

    // R10 go key while active (no service key first)
    do_reset();
    setup(64'd50, 64'd0, TC_CONT);
    arm();
    wr(A_WD, W_GO);
    check("R10 go key while active", timeout, 1);

    // R10 arm key twice in service
    do_reset();
    setup(64'd50, 64'd0, TC_CONT);
    arm();
    wr(A_WD, W_ARM);
    check("R9 service entry no timeout", timeout, 0);
    wr(A_WD, W_ARM);
    check("R10 bad key in service", timeout, 1);

    // R9 randomized service and expiry
    for (int it = 0; it < 10; it++) begin
      logic [63:0] prd, pre;
      int unsigned w;
      prd = 64'($urandom_range(60, 4));
      pre = 64'($urandom_range(int'(prd) - 2, 0));
      w   = $urandom_range(int'(prd - pre) - 1, 0);
      do_reset();
      setup(prd, pre, ($urandom_range(1, 0) != 0) ? TC_CONT : 32'h40);
      arm();
      tick = 1'b1; repeat (w) @(negedge clk); tick = 1'b0;
      rd(A_CL, v); check("R5 random count", v, pre + 64'(w));
      wr(A_WD, 32'hA5C6_0000);
      wr(A_WD, 32'hDA7E_0000);
      rd(A_CL, v); check("R9 service clears counter", v, 0);
      check("R9 no timeout after service", timeout, 0);
      run_to_expiry("R9", 64'd0, prd);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule